// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two execute-stage ALU operands comes from in a five-stage load/store pipeline. It compares the two source register numbers of the instruction about to execute with the destination register numbers of the two older instructions still in flight. One older instruction has just left execute and holds an ALU result. The other is about to write back and holds its write-back value. When an older instruction is going to write a register that the current instruction reads, its value is used in place of the stale register-file value.

Each operand gets its own select code and its own three-way multiplexer. The decision logic is combinational. The selects and the chosen operand values are captured in one output register stage, so a consumer sees them one clock after the inputs are presented. The block does not generate stalls. The ALU, the register file and the memories are outside it.

Top module: `operand_bypass`

## Requirements
- R1: While `rst_n` is low, `sel_a` and `sel_b` read 2'b00 and `opnd_a` and `opnd_b` read zero, whatever the other inputs are.
- R2: If `exm_wr` is 1, `exm_dst` is nonzero and `exm_dst` equals `idex_rs`, then `sel_a` is 2'b10 and `opnd_a` equals `exm_result`.
- R3: If the R2 condition for operand A does not hold, and `wb_wr` is 1, `wb_dst` is nonzero and `wb_dst` equals `idex_rs`, then `sel_a` is 2'b01 and `opnd_a` equals `wb_data`.
- R4: If `exm_wr` is 1, `exm_dst` is nonzero and `exm_dst` equals `idex_rt`, then `sel_b` is 2'b10 and `opnd_b` equals `exm_result`.
- R5: If the R4 condition for operand B does not hold, and `wb_wr` is 1, `wb_dst` is nonzero and `wb_dst` equals `idex_rt`, then `sel_b` is 2'b01 and `opnd_b` equals `wb_data`.
- R6: When both older stages name the same source register and both write, the newer stage (`exm_*`) is chosen, with select 2'b10.
- R7: A stage whose write enable (`exm_wr` or `wb_wr`) is 0 is never chosen, even when its register number matches.
- R8: A destination register number of zero is never chosen, even with its write enable set and a matching source number.
- R9: When neither stage is chosen for an operand, its select is 2'b00 and its value is the register-file read data (`rf_rdata_a` or `rf_rdata_b`).
- R10: The two operands are decided independently. Both can be bypassed in the same cycle, from the same stage or from different stages, including when `idex_rs` equals `idex_rt`.
- R11: Every output reflects the inputs sampled at the previous rising clock edge, and a select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idex_rs | input | AW | First source register number of the executing instruction |
| idex_rt | input | AW | Second source register number of the executing instruction |
| rf_rdata_a | input | DW | Register-file value for operand A |
| rf_rdata_b | input | DW | Register-file value for operand B |
| exm_dst | input | AW | Destination register of the instruction just past execute |
| exm_wr | input | 1 | Register write enable of that instruction |
| exm_result | input | DW | ALU result of that instruction |
| wb_dst | input | AW | Destination register of the instruction in write-back |
| wb_wr | input | 1 | Register write enable of the write-back instruction |
| wb_data | input | DW | Write-back value |
| sel_a | output | 2 | Source select for operand A (00 file, 10 newer stage, 01 older stage) |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DW | Selected value for operand A |
| opnd_b | output | DW | Selected value for operand B |

## Verification
The stimulus covers these cases for each operand separately:
- no match, which should pick the register file;
- a match in only the newer stage, and a match in only the older stage;
- matches in both stages, which shows whether the priority is right;
- a match whose write enable is low, and a match on register zero, which show whether the qualifiers are enforced.

Cases that bypass both operands at once, from the same stage or from mixed stages, and a case with identical source numbers, show whether the two select paths leak into each other. Every data input gets a distinct value in every cycle, so a wrong multiplexer leg shows up in the operand value as well as in the select code. The highest register number is also tried. The reset case holds a matching pattern on the inputs while reset is low.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int unsigned REG_AW_DEF = 5;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned NUM_OPND   = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EXM = 2'b10
    } byp_sel_e;

endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src_id,
    input  logic [AW-1:0] dst_id,
    input  logic          dst_wr,
    output logic          hit
);

    logic dst_nonzero;

    always_comb begin
        dst_nonzero = (dst_id != '0);
        hit         = dst_wr && dst_nonzero && (dst_id == src_id);
    end

endmodule

// File: rtl/bypass_prio.sv
module bypass_prio
    import bypass_pkg::*;
(
    input  logic     hit_exm,
    input  logic     hit_wb,
    output byp_sel_e sel
);

    always_comb begin
        if (hit_exm) begin
            sel = SEL_EXM;
        end else if (hit_wb) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_RF;
        end
    end

endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
    import bypass_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  byp_sel_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] exm_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] y
);

    always_comb begin
        case (sel)
            SEL_EXM: y = exm_val;
            SEL_WB:  y = wb_val;
            default: y = rf_val;
        endcase
    end

endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
    import bypass_pkg::*;
#(
    parameter int unsigned AW = REG_AW_DEF,
    parameter int unsigned DW = DATA_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idex_rs,
    input  logic [AW-1:0] idex_rt,
    input  logic [DW-1:0] rf_rdata_a,
    input  logic [DW-1:0] rf_rdata_b,
    input  logic [AW-1:0] exm_dst,
    input  logic          exm_wr,
    input  logic [DW-1:0] exm_result,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    input  logic [DW-1:0] wb_data,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);

    localparam int unsigned NOP = NUM_OPND;

    typedef struct packed {
        logic [1:0]    sel_a;
        logic [1:0]    sel_b;
        logic [DW-1:0] opnd_a;
        logic [DW-1:0] opnd_b;
    } out_t;

    logic [AW-1:0] src_id  [NOP];
    logic [DW-1:0] rf_val  [NOP];
    logic          hit_exm [NOP];
    logic          hit_wb  [NOP];
    byp_sel_e      sel_c   [NOP];
    logic [DW-1:0] opnd_c  [NOP];

    out_t out_d;
    out_t out_q;

    assign src_id[0] = idex_rs;
    assign src_id[1] = idex_rt;
    assign rf_val[0] = rf_rdata_a;
    assign rf_val[1] = rf_rdata_b;

    for (genvar g = 0; g < NOP; g++) begin : g_opnd
        bypass_match #(.AW(AW)) u_match_exm (
            .src_id (src_id[g]),
            .dst_id (exm_dst),
            .dst_wr (exm_wr),
            .hit    (hit_exm[g])
        );

        bypass_match #(.AW(AW)) u_match_wb (
            .src_id (src_id[g]),
            .dst_id (wb_dst),
            .dst_wr (wb_wr),
            .hit    (hit_wb[g])
        );

        bypass_prio u_prio (
            .hit_exm (hit_exm[g]),
            .hit_wb  (hit_wb[g]),
            .sel     (sel_c[g])
        );

        bypass_mux #(.DW(DW)) u_mux (
            .sel     (sel_c[g]),
            .rf_val  (rf_val[g]),
            .exm_val (exm_result),
            .wb_val  (wb_data),
            .y       (opnd_c[g])
        );
    end

    always_comb begin
        out_d        = out_q;
        out_d.sel_a  = sel_c[0];
        out_d.sel_b  = sel_c[1];
        out_d.opnd_a = opnd_c[0];
        out_d.opnd_b = opnd_c[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sel_a  = out_q.sel_a;
    assign sel_b  = out_q.sel_b;
    assign opnd_a = out_q.opnd_a;
    assign opnd_b = out_q.opnd_b;

endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] idex_rs,
    input logic [AW-1:0] idex_rt,
    input logic [DW-1:0] rf_rdata_a,
    input logic [DW-1:0] rf_rdata_b,
    input logic [AW-1:0] exm_dst,
    input logic          exm_wr,
    input logic [DW-1:0] exm_result,
    input logic [AW-1:0] wb_dst,
    input logic          wb_wr,
    input logic [DW-1:0] wb_data,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b
);

    logic a_exm, a_wb, b_exm, b_wb;

    assign a_exm = exm_wr && (exm_dst != '0) && (exm_dst == idex_rs);
    assign a_wb  = wb_wr  && (wb_dst  != '0) && (wb_dst  == idex_rs);
    assign b_exm = exm_wr && (exm_dst != '0) && (exm_dst == idex_rt);
    assign b_wb  = wb_wr  && (wb_dst  != '0) && (wb_dst  == idex_rt);

    AST_A_FROM_EXM: assert property (@(posedge clk) disable iff (!rst_n)
        a_exm |=> (sel_a == 2'b10) && (opnd_a == $past(exm_result))); // R2

    AST_A_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_exm && a_wb) |=> (sel_a == 2'b01) && (opnd_a == $past(wb_data))); // R3

    AST_B_FROM_EXM: assert property (@(posedge clk) disable iff (!rst_n)
        b_exm |=> (sel_b == 2'b10) && (opnd_b == $past(exm_result))); // R4

    AST_B_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_exm && b_wb) |=> (sel_b == 2'b01) && (opnd_b == $past(wb_data))); // R5

    AST_A_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_exm && !a_wb) |=> (sel_a == 2'b00) && (opnd_a == $past(rf_rdata_a))); // R9

    AST_B_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_exm && !b_wb) |=> (sel_b == 2'b00) && (opnd_b == $past(rf_rdata_b))); // R9

    AST_WR_OFF_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!exm_wr && !wb_wr) |=> (sel_a == 2'b00) && (sel_b == 2'b00)); // R7

    AST_ZERO_DST_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (exm_dst == '0 && wb_dst == '0) |=> (sel_a == 2'b00) && (sel_b == 2'b00)); // R8

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11)); // R11

endmodule

bind operand_bypass operand_bypass_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idex_rs    (idex_rs),
    .idex_rt    (idex_rt),
    .rf_rdata_a (rf_rdata_a),
    .rf_rdata_b (rf_rdata_b),
    .exm_dst    (exm_dst),
    .exm_wr     (exm_wr),
    .exm_result (exm_result),
    .wb_dst     (wb_dst),
    .wb_wr      (wb_wr),
    .wb_data    (wb_data),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b)
);

// File: tb/operand_bypass_bench.sv
module operand_bypass_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] idex_rs = '0;
    logic [AW-1:0] idex_rt = '0;
    logic [DW-1:0] rf_rdata_a = '0;
    logic [DW-1:0] rf_rdata_b = '0;
    logic [AW-1:0] exm_dst = '0;
    logic          exm_wr = 1'b0;
    logic [DW-1:0] exm_result = '0;
    logic [AW-1:0] wb_dst = '0;
    logic          wb_wr = 1'b0;
    logic [DW-1:0] wb_data = '0;
    logic [1:0]    sel_a;
    logic [1:0]    sel_b;
    logic [DW-1:0] opnd_a;
    logic [DW-1:0] opnd_b;

    typedef struct {
        logic [1:0]    ea;
        logic [1:0]    eb;
        logic [DW-1:0] va;
        logic [DW-1:0] vb;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   stamp  = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    operand_bypass #(.AW(AW), .DW(DW)) u_operand_bypass (
        .clk        (clk),
        .rst_n      (rst_n),
        .idex_rs    (idex_rs),
        .idex_rt    (idex_rt),
        .rf_rdata_a (rf_rdata_a),
        .rf_rdata_b (rf_rdata_b),
        .exm_dst    (exm_dst),
        .exm_wr     (exm_wr),
        .exm_result (exm_result),
        .wb_dst     (wb_dst),
        .wb_wr      (wb_wr),
        .wb_data    (wb_data),
        .sel_a      (sel_a),
        .sel_b      (sel_b),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b)
    );

    function automatic logic [DW-1:0] pick(logic [1:0] s, logic [DW-1:0] rf,
                                           logic [DW-1:0] ex, logic [DW-1:0] wb);
        if (s == 2'b10) return ex;
        if (s == 2'b01) return wb;
        return rf;
    endfunction

    task automatic check_val(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: one vector per cycle, expected outputs pushed to the scoreboard
    task automatic drive(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                         input logic [AW-1:0] ed, input logic ew,
                         input logic [AW-1:0] wd, input logic ww,
                         input logic [1:0] ea, input logic [1:0] eb, input string tag);
        exp_t e;
        @(negedge clk);
        stamp++;
        idex_rs    = rs;
        idex_rt    = rt;
        exm_dst    = ed;
        exm_wr     = ew;
        wb_dst     = wd;
        wb_wr      = ww;
        rf_rdata_a = 32'hA000_0000 + 32'(stamp);
        rf_rdata_b = 32'hB000_0000 + 32'(stamp);
        exm_result = 32'hE000_0000 + 32'(stamp);
        wb_data    = 32'hC000_0000 + 32'(stamp);
        e.ea  = ea;
        e.eb  = eb;
        e.va  = pick(ea, rf_rdata_a, exm_result, wb_data);
        e.vb  = pick(eb, rf_rdata_b, exm_result, wb_data);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: result of each vector appears after the next rising edge (R11)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check_val(e.tag, "sel_a",  32'(sel_a), 32'(e.ea));
                check_val(e.tag, "sel_b",  32'(sel_b), 32'(e.eb));
                check_val(e.tag, "opnd_a", opnd_a, e.va);
                check_val(e.tag, "opnd_b", opnd_b, e.vb);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: matching pattern held during reset, outputs must stay zero
        idex_rs    = 5'd3;
        idex_rt    = 5'd3;
        exm_dst    = 5'd3;
        exm_wr     = 1'b1;
        exm_result = 32'hDEAD_BEEF;
        wb_dst     = 5'd3;
        wb_wr      = 1'b1;
        wb_data    = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1", "sel_a",  32'(sel_a), 32'd0);
        check_val("R1", "sel_b",  32'(sel_b), 32'd0);
        check_val("R1", "opnd_a", opnd_a, 32'd0);
        check_val("R1", "opnd_b", opnd_b, 32'd0);
        rst_n = 1'b1;

        //     rs      rt      exm_d  ew    wb_d   ww    ea     eb
        drive(5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00, "R9 no match");
        drive(5'd5,  5'd6,  5'd5,  1'b1, 5'd7,  1'b1, 2'b10, 2'b00, "R2 A newer");
        drive(5'd8,  5'd9,  5'd3,  1'b1, 5'd8,  1'b1, 2'b01, 2'b00, "R3 A older");
        drive(5'd1,  5'd10, 5'd10, 1'b1, 5'd4,  1'b1, 2'b00, 2'b10, "R4 B newer");
        drive(5'd1,  5'd11, 5'd3,  1'b1, 5'd11, 1'b1, 2'b00, 2'b01, "R5 B older");
        drive(5'd12, 5'd2,  5'd12, 1'b1, 5'd12, 1'b1, 2'b10, 2'b00, "R6 A both");
        drive(5'd1,  5'd13, 5'd13, 1'b1, 5'd13, 1'b1, 2'b00, 2'b10, "R6 B both");
        drive(5'd14, 5'd2,  5'd14, 1'b0, 5'd3,  1'b1, 2'b00, 2'b00, "R7 newer off");
        drive(5'd15, 5'd2,  5'd15, 1'b0, 5'd15, 1'b1, 2'b01, 2'b00, "R7 newer off older on");
        drive(5'd1,  5'd16, 5'd3,  1'b1, 5'd16, 1'b0, 2'b00, 2'b00, "R7 older off");
        drive(5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, "R8 zero reg");
        drive(5'd0,  5'd20, 5'd0,  1'b1, 5'd20, 1'b1, 2'b00, 2'b01, "R8 zero newer");
        drive(5'd17, 5'd18, 5'd17, 1'b1, 5'd18, 1'b1, 2'b10, 2'b01, "R10 mixed");
        drive(5'd19, 5'd19, 5'd19, 1'b1, 5'd2,  1'b1, 2'b10, 2'b10, "R10 same src");
        drive(5'd20, 5'd21, 5'd21, 1'b1, 5'd20, 1'b1, 2'b01, 2'b10, "R10 swapped");
        drive(5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b1, 2'b10, 2'b01, "R2 R5 top reg");
        drive(5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00, "R11 return to file");

        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11 pending: actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule